// File: doc/BRIEF.md
# Two-source glitch-free clock switch

This block chooses which of two free-running clocks, a primary and a secondary, drives an array of identical clock outputs. A change of the select input never produces a runt pulse. The outgoing clock is gated off on one of its own falling edges. Only once that source's synchronizer has fully drained does the incoming clock's gate start to fill, and it opens on a falling edge of the incoming clock. During the handover every output sits low.

If the outgoing clock has stopped, whether held high or held low, the handover cannot finish, because its gate never sees the edges it needs. A force input clears the deselected source's synchronizer at once, so the new source can take over on its own edges. An output enable that is asynchronous to both clocks can park every output at a static level, and a separate input chooses that level. After an active-low asynchronous reset both gates are closed. The primary gate then opens after synchronization.

Top module: `dual_clk_switch`

## Requirements
- R1: While reset is low, every output is 0 (enable high). After reset is released with the select at 0, the primary gate opens no later than the third primary falling edge, and from then on the outputs follow the primary clock.
- R2: Select value 0 picks the primary clock and value 1 picks the secondary clock. Once the handover has settled, every output equals the picked clock.
- R3: The two source gates are never open at the same time.
- R4: With the enable held high and no force, repeated switchovers produce no output high or low pulse shorter than half the period of the faster input clock.
- R5: After the select changes, the old gate is closed by the third falling edge of the old clock, and the outputs are low from then on. The new gate opens only on edges of the new clock, no later than its third falling edge after the old gate has closed.
- R6: If the old clock has stopped and force is low, the switchover waits and the outputs keep the stopped clock's level. With force high, the deselected source is cleared at once (outputs go low) and the new clock reaches the outputs after at most three of its own falling edges.
- R7: While the enable is 0, every output equals the park-level input at once and stays there, whatever the clocks or a switchover in progress are doing.
- R8: All fanout outputs carry the same value at all times.
- R9: When the enable returns to 1, the outputs follow whichever source the select has settled on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary source clock |
| clk_sec | input | 1 | Secondary source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_sec | input | 1 | Source select: 0 primary, 1 secondary |
| force_sw | input | 1 | Clear the deselected source without waiting for its edges |
| out_en | input | 1 | Asynchronous output enable, high passes the clock |
| park_lvl | input | 1 | Static level driven on all outputs while disabled |
| clk_fan | output | N_OUT (10) | Identically gated clock outputs |

## Verification
A switchover in progress and a disable of the outputs can overlap: the enable can fall while one gate is draining and the other is filling. The bench drops the enable, with a random park level, right after a select change and also at random points during random switch sequences. It judges that every output holds the park level for the whole window and that, after re-enable, the outputs follow the newly selected clock edge for edge. A second overlap, force raised in the same step as the select change while the old clock is stuck, is judged by the immediate low and the new clock's arrival within three of its falling edges.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  // number of selectable sources and their positions in the source vectors
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned PRI_IDX = 0;
  localparam int unsigned SEC_IDX = 1;

  // falling-edge stages per source; two keeps each side within three edges
  localparam int unsigned SYNC_DEPTH = 2;

  // a source may ask to open only while chosen and while the other
  // source's synchronizer holds no set bit anywhere in its pipeline
  function automatic logic src_request(input logic chosen, input logic other_busy);
    return chosen & ~other_busy;
  endfunction

  // active-low clear of one source's pipeline: reset, or forced drain of
  // a source that is no longer chosen
  function automatic logic stage_clear_n(input logic rst_n, input logic force_sw,
                                         input logic chosen);
    return rst_n & ~(force_sw & ~chosen);
  endfunction

  // value on an output pin: the merged clock when enabled, else the park level
  function automatic logic park_or_pass(input logic en, input logic clk_in,
                                        input logic lvl);
    return en ? clk_in : lvl;
  endfunction

endpackage

// File: rtl/clksw_src_gate.sv
module clksw_src_gate #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic clr_n_i,
  input  logic req_i,
  output logic on_o,
  output logic busy_o,
  output logic gclk_o
);

  // shift register clocked on the falling edge so that the gate bit only
  // changes while this source's clock is low
  logic [DEPTH-1:0] sync_q;

  always_ff @(negedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[DEPTH-2:0], req_i};
  end

  assign on_o   = sync_q[DEPTH-1];
  assign busy_o = |sync_q;
  assign gclk_o = clk_i & on_o;

endmodule

// File: rtl/clksw_park.sv
module clksw_park
  import clksw_pkg::*;
(
  input  logic en_i,
  input  logic lvl_i,
  input  logic clk_i,
  output logic out_o
);

  assign out_o = park_or_pass(en_i, clk_i, lvl_i);

endmodule

// File: rtl/clksw_fanout.sv
module clksw_fanout #(
  parameter int unsigned N_OUT = 10
) (
  input  logic             clk_i,
  output logic [N_OUT-1:0] clk_o
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_leg
    assign clk_o[o] = clk_i;
  end

endmodule

// File: rtl/dual_clk_switch.sv
module dual_clk_switch
  import clksw_pkg::*;
#(
  parameter int unsigned N_OUT = 10
) (
  input  logic             clk_pri,
  input  logic             clk_sec,
  input  logic             rst_n,
  input  logic             sel_sec,
  input  logic             force_sw,
  input  logic             out_en,
  input  logic             park_lvl,
  output logic [N_OUT-1:0] clk_fan
);

  localparam int unsigned LAST_SRC = NUM_SRC - 1;

  logic [LAST_SRC:0] src_clk;
  logic [LAST_SRC:0] chosen;
  logic [LAST_SRC:0] req;
  logic [LAST_SRC:0] clr_n;
  logic [LAST_SRC:0] gate_on;
  logic [LAST_SRC:0] busy;
  logic [LAST_SRC:0] gclk;

  // named events for the checker
  logic pri_on;
  logic sec_on;
  logic clk_merged;
  logic clk_pin;

  assign src_clk[PRI_IDX] = clk_pri;
  assign src_clk[SEC_IDX] = clk_sec;
  assign chosen[PRI_IDX]  = ~sel_sec;
  assign chosen[SEC_IDX]  = sel_sec;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign req[g]   = src_request(chosen[g], busy[LAST_SRC-g]);
    assign clr_n[g] = stage_clear_n(rst_n, force_sw, chosen[g]);

    clksw_src_gate #(
      .DEPTH (SYNC_DEPTH)
    ) u_gate (
      .clk_i   (src_clk[g]),
      .clr_n_i (clr_n[g]),
      .req_i   (req[g]),
      .on_o    (gate_on[g]),
      .busy_o  (busy[g]),
      .gclk_o  (gclk[g])
    );
  end

  assign pri_on     = gate_on[PRI_IDX];
  assign sec_on     = gate_on[SEC_IDX];
  assign clk_merged = |gclk;

  clksw_park u_park (
    .en_i  (out_en),
    .lvl_i (park_lvl),
    .clk_i (clk_merged),
    .out_o (clk_pin)
  );

  clksw_fanout #(
    .N_OUT (N_OUT)
  ) u_fan (
    .clk_i (clk_pin),
    .clk_o (clk_fan)
  );

endmodule

// File: rtl/clksw_chk.sv
module clksw_chk #(
  parameter int unsigned N_OUT = 10
) (
  input logic             clk_pri,
  input logic             clk_sec,
  input logic             rst_n,
  input logic             sel_sec,
  input logic             force_sw,
  input logic             out_en,
  input logic             park_lvl,
  input logic [N_OUT-1:0] clk_fan,
  input logic             pri_on,
  input logic             sec_on
);

  // R3: gates mutually exclusive, seen from either clock
  a_r3_excl_pri: assert property (@(posedge clk_pri) disable iff (!rst_n)
    !(pri_on && sec_on));
  a_r3_excl_sec: assert property (@(posedge clk_sec) disable iff (!rst_n)
    !(pri_on && sec_on));

  // R5: three falling edges with the other source chosen close the gate
  a_r5_pri_closes: assert property (@(negedge clk_pri) disable iff (!rst_n)
    (sel_sec && $past(sel_sec) && $past(sel_sec, 2)) |-> !pri_on);
  a_r5_sec_closes: assert property (@(negedge clk_sec) disable iff (!rst_n)
    (!sel_sec && !$past(sel_sec) && !$past(sel_sec, 2)) |-> !sec_on);

  // R6: force drains the deselected source without its own edges
  a_r6_force_pri: assert property (@(posedge clk_sec) disable iff (!rst_n)
    (force_sw && sel_sec) |-> !pri_on);
  a_r6_force_sec: assert property (@(posedge clk_pri) disable iff (!rst_n)
    (force_sw && !sel_sec) |-> !sec_on);

  // R7: parked outputs
  a_r7_park: assert property (@(posedge clk_pri) disable iff (!rst_n)
    !out_en |-> (clk_fan == {N_OUT{park_lvl}}));

  // R8: all legs equal
  a_r8_fan_equal: assert property (@(posedge clk_sec) disable iff (!rst_n)
    clk_fan == {N_OUT{clk_fan[0]}});

endmodule

bind dual_clk_switch clksw_chk #(
  .N_OUT (N_OUT)
) u_chk (
  .clk_pri  (clk_pri),
  .clk_sec  (clk_sec),
  .rst_n    (rst_n),
  .sel_sec  (sel_sec),
  .force_sw (force_sw),
  .out_en   (out_en),
  .park_lvl (park_lvl),
  .clk_fan  (clk_fan),
  .pri_on   (pri_on),
  .sec_on   (sec_on)
);

// File: tb/dual_clk_switch_tb.sv
module dual_clk_switch_tb_top;

  localparam int N_OUT    = 10;
  localparam int HALF_TB  = 2500;   // 200 MHz bench clock, 1 ps units
  localparam int HALF_PRI = 4000;
  localparam int HALF_SEC = 6500;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic clk_pri = 1'b0;
  logic clk_sec = 1'b0;
  bit   pri_run = 1'b1;
  bit   sec_run = 1'b1;
  logic rst_n = 1'b0;
  logic sel_sec = 1'b0;
  logic force_sw = 1'b0;
  logic out_en = 1'b1;
  logic park_lvl = 1'b0;
  logic [N_OUT-1:0] clk_fan;

  int  n_vec = 0;
  int  n_bad = 0;
  int  cycles = 0;
  bit  pulse_chk = 1'b0;
  bit  have_edge = 1'b0;
  longint last_edge = 0;

  dual_clk_switch #(.N_OUT(N_OUT)) dut_i (
    .clk_pri (clk_pri), .clk_sec (clk_sec), .rst_n (rst_n),
    .sel_sec (sel_sec), .force_sw (force_sw), .out_en (out_en),
    .park_lvl (park_lvl), .clk_fan (clk_fan)
  );

  // bench clock offset so its edges never meet a source clock edge
  initial begin #1300; forever #HALF_TB clk = ~clk; end
  initial forever begin #HALF_PRI; if (pri_run) clk_pri = ~clk_pri; end
  initial forever begin #HALF_SEC; if (sec_run) clk_sec = ~clk_sec; end

  function automatic logic [N_OUT-1:0] exp_fan(input logic en, input logic lvl,
                                               input logic src);
    return en ? {N_OUT{src}} : {N_OUT{lvl}};
  endfunction

  function automatic longint min_pulse();
    return (HALF_PRI < HALF_SEC) ? HALF_PRI : HALF_SEC;
  endfunction

  task automatic chk(input string req, input logic [N_OUT-1:0] exp);
    n_vec++;
    if (clk_fan !== exp) begin
      n_bad++;
      $display("FAIL %s: clk_fan=%b expected %b at %0t", req, clk_fan, exp, $time);
    end
  endtask

  // R4: pulse width monitor
  always @(clk_fan[0]) begin
    if (pulse_chk && have_edge) begin
      n_vec++;
      if ($time - last_edge < min_pulse()) begin
        n_bad++;
        $display("FAIL R4: pulse width %0d expected >= %0d at %0t",
                 $time - last_edge, min_pulse(), $time);
      end
    end
    last_edge = $time;
    have_edge = pulse_chk;
  end

  task automatic pulse_on();  have_edge = 1'b0; pulse_chk = 1'b1; endtask
  task automatic pulse_off(); pulse_chk = 1'b0; endtask

  task automatic follow(input logic sec, input string req, input int n);
    for (int i = 0; i < n; i++) begin
      if (sec) @(posedge clk_sec); else @(posedge clk_pri);
      #1000 chk(req, exp_fan(out_en, park_lvl, 1'b1));
      if (sec) @(negedge clk_sec); else @(negedge clk_pri);
      #1000 chk(req, exp_fan(out_en, park_lvl, 1'b0));
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_pri);
    repeat (4) @(negedge clk_sec);
    repeat (4) @(negedge clk_pri);
  endtask

  task automatic stop_pri(input logic lvl);
    wait (clk_pri == lvl); pri_run = 1'b0;
  endtask
  task automatic stop_sec(input logic lvl);
    wait (clk_sec == lvl); sec_run = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not end, cycles=%0d expected < %0d", cycles, WD_LIMIT);
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'hB0A7);

    // R1: reset state
    repeat (6) @(posedge clk);
    chk("R1", '0);
    @(posedge clk_pri); #1000 chk("R1", '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk_pri);
    @(posedge clk_pri); #1000 chk("R1", '1);
    follow(1'b0, "R1", 4);

    // R5 and R2: secondary halted low, old gate must close on its own
    stop_sec(1'b0);
    @(negedge clk); sel_sec = 1'b1;
    repeat (3) @(negedge clk_pri);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_pri); #1000 chk("R5", '0);
    end
    sec_run = 1'b1;
    repeat (3) @(negedge clk_sec);
    @(posedge clk_sec); #1000 chk("R5", '1);
    follow(1'b1, "R2", 4);

    // R4 and R2: back to primary with pulse widths watched
    pulse_on();
    @(negedge clk); sel_sec = 1'b0;
    settle();
    follow(1'b0, "R2", 3);
    pulse_off();

    // R6: primary stuck high, no force then force
    stop_pri(1'b1);
    @(negedge clk); sel_sec = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk_sec); #1000 chk("R6", '1);
    end
    @(negedge clk); force_sw = 1'b1;
    #1000 chk("R6", '0);
    repeat (3) @(negedge clk_sec);
    @(posedge clk_sec); #1000 chk("R6", '1);
    follow(1'b1, "R6", 3);
    @(negedge clk); force_sw = 1'b0;
    pri_run = 1'b1;

    // R6: secondary stuck low, force raised together with the select
    stop_sec(1'b0);
    @(negedge clk); sel_sec = 1'b0; force_sw = 1'b1;
    repeat (3) @(negedge clk_pri);
    follow(1'b0, "R6", 3);
    @(negedge clk); force_sw = 1'b0;
    sec_run = 1'b1;
    settle();

    // R7, R8, R9: parking at both levels
    @(negedge clk); out_en = 1'b0; park_lvl = 1'b1;
    #1000 chk("R7", '1);
    follow(1'b0, "R7", 3);
    @(negedge clk); park_lvl = 1'b0;
    #1000 chk("R7", '0);
    follow(1'b0, "R8", 2);
    @(negedge clk); out_en = 1'b1;
    follow(1'b0, "R9", 3);

    // R7 and R9: disable overlapping a switchover
    @(negedge clk); sel_sec = 1'b1;
    @(negedge clk); out_en = 1'b0; park_lvl = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk_sec); #1000 chk("R7", '1);
    end
    @(negedge clk); out_en = 1'b1;
    settle();
    follow(1'b1, "R9", 3);

    // random switch sequences, parking and waits
    for (int it = 0; it < 40; it++) begin
      r = $urandom();
      case (r % 4)
        0: begin
          pulse_on();
          @(negedge clk); sel_sec = ~sel_sec;
          settle();
          follow(sel_sec, "R4", 2);
          pulse_off();
        end
        1: begin
          @(negedge clk); out_en = 1'b0; park_lvl = r[8];
          if (r[9]) sel_sec = ~sel_sec;
          for (int k = 0; k < int'(r[14:10] % 20) + 1; k++) begin
            @(posedge clk); chk("R7", {N_OUT{r[8]}});
          end
          @(negedge clk); out_en = 1'b1;
          settle();
          follow(sel_sec, "R9", 2);
        end
        2: begin
          repeat (int'(r[15:10] % 40) + 1) @(posedge clk);
          follow(sel_sec, "R2", 2);
        end
        default: begin
          pulse_on();
          @(negedge clk); sel_sec = ~sel_sec;
          repeat (int'(r[13:10] % 12) + 1) @(negedge clk);
          sel_sec = ~sel_sec;
          settle();
          follow(sel_sec, "R3", 2);
          pulse_off();
        end
      endcase
    end

    summary();
    $finish;
  end

endmodule